// File: doc/BRIEF.md
# Error-Tagged Receive FIFO with Line-Status Interrupt

This block sits between a serial receiver and the host side of a UART channel. Each received byte is stored together with three error tags: parity, framing and break. The block keeps these bytes in a first-in, first-out buffer. The error flags it presents describe only the byte the host will read next, while a single summary flag reports whether any stored byte carries an error. An overrun condition is tracked separately and is sticky until the host reads the status.

A pending line-status interrupt is raised in three cases. The first is an overrun. The second is the moment an errored byte is accepted, wherever it lands in the queue. The third is the moment an errored byte moves to the head through a host read. Reading the status clears the pending request. This means a host that acknowledged the first interrupt is called back once the offending byte is actually next to be read. An enable input gates the request at the output but does not stop it from latching.

Top module: `rxf_lsr_top`

## Requirements
- R1: Accepted bytes are returned in arrival order on `head_data`. The buffer holds up to DEPTH (default 16) bytes. A push while full is discarded unless a pop is accepted in the same cycle.
- R2: `err_flags[1]` (parity), `err_flags[2]` (framing) and `err_flags[3]` (break) show the tags of the head entry only. They are 0 while the buffer is empty.
- R3: `any_err` is 1 whenever at least one stored entry carries any tag, and 0 once no stored entry does.
- R4: `err_flags[0]` (overrun) is set by a discarded push or by an `rx_ovr` strobe. It is cleared by `lsr_rd`, and a set in the same cycle wins over the clear.
- R5: An accepted push with any tag set raises the pending interrupt on the next cycle, even when other bytes are ahead of it. An overrun event also raises it.
- R6: An accepted pop that leaves a tagged entry at the head raises the pending interrupt.
- R7: `lsr_rd` clears the pending interrupt unless a raise condition occurs in the same cycle.
- R8: `irq` equals the pending interrupt ANDed with `irq_en`. The pending state latches while `irq_en` is 0.
- R9: A pop on an empty buffer changes nothing. When empty, `head_data` shows the most recently popped byte.
- R10: After reset the buffer is empty, `head_data`, `err_flags`, `any_err` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Received byte strobe |
| rx_data | input | DW | Received byte |
| rx_perr | input | 1 | Parity error tag of the received byte |
| rx_ferr | input | 1 | Framing error tag of the received byte |
| rx_brk | input | 1 | Break tag of the received byte |
| rx_ovr | input | 1 | External overrun strobe |
| rd_pop | input | 1 | Host reads the head byte |
| lsr_rd | input | 1 | Host reads line status |
| irq_en | input | 1 | Line-status interrupt enable |
| head_data | output | DW | Head byte, or last popped byte when empty |
| err_flags | output | 4 | {break, framing, parity, overrun} |
| any_err | output | 1 | Some stored entry carries a tag |
| irq | output | 1 | Line-status interrupt request |

## Verification
The bench replays a clean byte followed by a parity-tagged byte, acknowledges the interrupt, then pops. A design that ignores head arrival would stay silent here. A design that reports tags globally would show parity while the clean byte is still at the head. Filling past the depth checks that the extra byte is dropped and overrun is set. A design that overwrote the oldest entry or forgot the drop would then return the wrong order. Other scenarios cover a status read colliding with a tagged push, where a plain clear would lose the interrupt, and pops on an empty buffer, where a stale pointer would change `head_data`. A long random run completes the checks, with a queue model compared on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rxf_tag_t;

   function automatic logic tag_any(input rxf_tag_t t);
      return t.brk | t.ferr | t.perr;
   endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
   import rxf_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [DW-1:0] wr_data,
   input  rxf_tag_t      wr_tag,
   input  logic          rd_req,
   output logic [DW-1:0] hd_data,
   output rxf_tag_t      hd_tag,
   output rxf_tag_t      nx_tag,
   output logic [CW-1:0] level,
   output logic          wr_ok,
   output logic          rd_ok
);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

   logic [DW-1:0] dmem [DEPTH];
   rxf_tag_t      tmem [DEPTH];
   logic [AW-1:0] wp, rp, wp_inc, rp_inc;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_inc = wp + AW'(1);
         assign rp_inc = rp + AW'(1);
      end else begin : g_wrap
         assign wp_inc = (wp == LAST_IX) ? '0 : wp + AW'(1);
         assign rp_inc = (rp == LAST_IX) ? '0 : rp + AW'(1);
      end
   endgenerate

   assign rd_ok = rd_req && (level != '0);
   assign wr_ok = wr_req && ((level != FULL_LVL) || rd_ok);

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         dmem[wp] <= wr_data;
         tmem[wp] <= wr_tag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (wr_ok) wp <= wp_inc;
         if (rd_ok) rp <= rp_inc;
         level <= level + CW'(wr_ok) - CW'(rd_ok);
      end
   end

   assign hd_data = dmem[rp];
   assign hd_tag  = (level != '0) ? tmem[rp] : '0;
   assign nx_tag  = (level > CW'(1)) ? tmem[rp_inc] : '0;

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_LVL);
   // R9
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !wr_req && level == '0) |=> (level == '0));
endmodule

// File: rtl/rxf_err_track.sv
module rxf_err_track #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ok,
   input  logic wr_any,
   input  logic drop,
   input  logic ovr_in,
   input  logic rd_ok,
   input  logic hd_any,
   input  logic nx_any,
   input  logic lsr_rd,
   output logic ovr_q,
   output logic pend_q,
   output logic some_err
);
   logic [CW-1:0] ecnt;
   logic          ovr_set, raise;

   assign ovr_set  = drop | ovr_in;
   assign raise    = ovr_set | (wr_ok & wr_any) | (rd_ok & nx_any);
   assign some_err = (ecnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt   <= '0;
         ovr_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         ecnt <= ecnt + CW'(wr_ok & wr_any) - CW'(rd_ok & hd_any);
         if (ovr_set)     ovr_q <= 1'b1;
         else if (lsr_rd) ovr_q <= 1'b0;
         if (raise)       pend_q <= 1'b1;
         else if (lsr_rd) pend_q <= 1'b0;
      end
   end

   // R4
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovr_q);
   // R5
   err_push_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_any) |=> pend_q);
   // R6
   head_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok && nx_any) |=> pend_q);
   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !ovr_in && !drop && !(wr_ok && wr_any) && !(rd_ok && nx_any)) |=> !pend_q);
endmodule

// File: rtl/rxf_lsr_top.sv
module rxf_lsr_top
   import rxf_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_perr,
   input  logic          rx_ferr,
   input  logic          rx_brk,
   input  logic          rx_ovr,
   input  logic          rd_pop,
   input  logic          lsr_rd,
   input  logic          irq_en,
   output logic [DW-1:0] head_data,
   output logic [3:0]    err_flags,
   output logic          any_err,
   output logic          irq
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxf_lsr_top: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("rxf_lsr_top: DW must be positive");
      end
   endgenerate

   rxf_tag_t      in_tag, hd_tag, nx_tag;
   logic [DW-1:0] mem_hd, last_q;
   logic [CW-1:0] level;
   logic          wr_ok, rd_ok, ovr_q, pend_q;

   assign in_tag = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr};

   rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_req(rx_push), .wr_data(rx_data), .wr_tag(in_tag),
      .rd_req(rd_pop),
      .hd_data(mem_hd), .hd_tag(hd_tag), .nx_tag(nx_tag),
      .level(level), .wr_ok(wr_ok), .rd_ok(rd_ok)
   );

   rxf_err_track #(.DEPTH(DEPTH)) u_track (
      .clk(clk), .rst_n(rst_n),
      .wr_ok(wr_ok), .wr_any(tag_any(in_tag)),
      .drop(rx_push & ~wr_ok), .ovr_in(rx_ovr),
      .rd_ok(rd_ok), .hd_any(tag_any(hd_tag)), .nx_any(tag_any(nx_tag)),
      .lsr_rd(lsr_rd),
      .ovr_q(ovr_q), .pend_q(pend_q), .some_err(any_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     last_q <= '0;
      else if (rd_ok) last_q <= mem_hd;
   end

   assign head_data = (level != '0) ? mem_hd : last_q;
   assign err_flags = {hd_tag.brk, hd_tag.ferr, hd_tag.perr, ovr_q};
   assign irq       = pend_q & irq_en;

   // R3
   head_in_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_err |-> (err_flags[3:1] == 3'b000));
   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);
endmodule

// File: tb/test_rxf_lsr_top.sv
module test_rxf_lsr_top;
   localparam int DW = 8;
   localparam int DEPTH = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_push = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, rx_ovr = 0;
   logic rd_pop = 0, lsr_rd = 0, irq_en = 1;
   logic [DW-1:0] rx_data = '0;
   logic [DW-1:0] head_data;
   logic [3:0]    err_flags;
   logic          any_err, irq;

   int checks = 0;
   int errors = 0;

   logic [10:0] q[$];
   logic        m_ovr = 0, m_pend = 0;
   logic [7:0]  m_last = 0;

   always #10 clk = ~clk;

   rxf_lsr_top #(.DW(DW), .DEPTH(DEPTH)) i_rxf_lsr_top (
      .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ovr(rx_ovr),
      .rd_pop(rd_pop), .lsr_rd(lsr_rd), .irq_en(irq_en),
      .head_data(head_data), .err_flags(err_flags), .any_err(any_err), .irq(irq)
   );

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [7:0] e_data;
      logic [2:0] e_tag;
      logic       e_any;
      e_any = 0;
      foreach (q[i]) if (q[i][10:8] != 0) e_any = 1;
      e_data = (q.size() != 0) ? q[0][7:0] : m_last;
      e_tag  = (q.size() != 0) ? q[0][10:8] : 3'b000;
      chk("R1 R9 head_data", head_data, e_data);
      chk("R2 head tag flags", err_flags[3:1], e_tag);
      chk("R4 overrun flag", err_flags[0], m_ovr);
      chk("R3 any_err", any_err, e_any);
      chk("R5 R6 R7 R8 irq", irq, m_pend & irq_en);
   endtask

   task automatic step(input logic push, input logic [7:0] d, input logic [2:0] tg,
                       input logic ovr, input logic pop, input logic lrd);
      logic pop_ok, push_ok, drop, raise;
      rx_push = push; rx_data = d; {rx_brk, rx_ferr, rx_perr} = tg;
      rx_ovr = ovr; rd_pop = pop; lsr_rd = lrd;
      pop_ok  = pop && q.size() > 0;
      push_ok = push && (q.size() < DEPTH || pop_ok);
      drop    = push && !push_ok;
      raise   = (push_ok && tg != 0) || drop || ovr ||
                (pop_ok && q.size() >= 2 && q[1][10:8] != 0);
      if (raise) m_pend = 1; else if (lrd) m_pend = 0;
      if (drop || ovr) m_ovr = 1; else if (lrd) m_ovr = 0;
      if (pop_ok) begin m_last = q[0][7:0]; void'(q.pop_front()); end
      if (push_ok) q.push_back({tg, d});
      @(negedge clk);
      rx_push = 0; rx_ovr = 0; rd_pop = 0; lsr_rd = 0;
      compare_all();
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset head_data", head_data, 0);
      chk("R10 reset flags", err_flags, 0);
      chk("R10 reset any_err", any_err, 0);
      chk("R10 reset irq", irq, 0);
      rst_n = 1;
      @(negedge clk);
      compare_all();

      // R2 R5: clean byte ahead of a parity byte
      step(1, 8'h55, 3'b000, 0, 0, 0);
      step(1, 8'hAA, 3'b001, 0, 0, 0);
      chk("R5 irq on errored byte behind head", irq, 1);
      chk("R2 head clean while parity byte queued", err_flags[1], 0);
      step(0, 0, 0, 0, 0, 1);
      chk("R7 irq cleared by status read", irq, 0);
      step(0, 0, 0, 0, 1, 0);
      chk("R6 irq again at head", irq, 1);
      chk("R2 parity on head", err_flags[1], 1);
      step(0, 0, 0, 0, 1, 1);
      chk("R3 any_err clears when drained", any_err, 0);
      // R9 pop on empty
      step(0, 0, 0, 0, 1, 0);
      chk("R9 head_data holds last", head_data, 8'hAA);

      // R1 R4 overflow
      for (int i = 0; i < DEPTH + 1; i++) step(1, 8'(i + 1), 3'b000, 0, 0, 0);
      chk("R4 overrun after full push", err_flags[0], 1);
      // R8 gating
      irq_en = 0; @(negedge clk); compare_all();
      chk("R8 irq masked", irq, 0);
      irq_en = 1; @(negedge clk); compare_all();
      chk("R8 pending kept while masked", irq, 1);
      // R7 collision: drain one, then status read with tagged push
      step(0, 0, 0, 0, 1, 0);
      step(1, 8'hC3, 3'b110, 0, 0, 1);
      chk("R7 raise wins over read", irq, 1);
      for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 1, 1);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [2:0] tg;
         tg = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
         irq_en = ($urandom_range(0, 9) != 0);
         step($urandom_range(0, 1) == 1, 8'($urandom), tg,
              $urandom_range(0, 40) == 0, $urandom_range(0, 9) < 4,
              $urandom_range(0, 6) == 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule